// File: doc/BRIEF.md
# In-Band Interrupt Requester (Target Side)

This block lets a target device on a two-wire SCL/SDA bus raise an in-band interrupt without a dedicated interrupt pin. A one-cycle strobe marks the request. The block waits until both lines have been idle-high long enough to count as a free bus. It then pulls SDA low as a start request. When the controller begins toggling SCL, the block sends its controller-assigned 7-bit dynamic address in open-drain form, followed by a read flag.

Several targets may request the bus at the same moment. The wired-AND line settles the contest bit by bit, so the lowest address is the one that survives. A losing target detects that it lost, releases the line and reports the loss. A winning target waits for the controller's acknowledge on the ninth clock. It may then push out one mandatory payload byte in push-pull mode. A not-acknowledge or a STOP ends the attempt early with an abort pulse.

The line inputs are already synchronised samples taken on the block clock. The three enable/value outputs drive an external pad. SDA is seen low whenever the open-drain enable is set, or when the push-pull enable is set with a low value.

Top module: `ibi_requester`

## Requirements
- R1: A request strobe is remembered and held pending. SDA is not driven until SCL and SDA have both been sampled high for AVAIL_CYC consecutive clocks. With AVAIL_CYC=16, the start request appears between 16 and 19 clocks after the lines go idle.
- R2: With a request pending on a free bus, the block sets `sda_od_oe` (SDA low) and holds it until the first SCL falling edge.
- R3: The dynamic address goes out MSB first, one bit per SCL low period. A 0 sets `sda_od_oe` and a 1 releases it. The eighth bit is a 1, meaning read. The line therefore shows address bits 6..0 and then 1.
- R4: If the block releases SDA for a 1 but samples SDA low at the SCL rising edge, it has lost arbitration. It releases SDA, pulses `lost_o`, drops the request and returns to idle. Against a competing address, the lower one completes on the line.
- R5: During the ninth SCL low period SDA is released. A low level at the ninth rising edge counts as an acknowledge.
- R6: A high level at the ninth rising edge (not-acknowledge) pulses `abort_o`, drops the request and returns to idle without sending a payload.
- R7: After an acknowledge with `has_payload_i` set, `payload_i` goes out MSB first through `sda_pp_oe`/`sda_pp_val`. The value changes only while SCL is low, and the open-drain enable stays off throughout.
- R8: The push-pull drive is released on the SCL falling edge after the eighth payload bit, and `done_o` pulses then. Without a payload, `done_o` pulses at the acknowledge.
- R9: A STOP (SDA rising while SCL stays high) seen after the start request releases SDA, pulses `abort_o` and returns to idle.
- R10: Each attempt ends with exactly one of `done_o`, `abort_o` or `lost_o`, and never two in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| dyn_addr_i | input | 7 | Controller-assigned dynamic address |
| irq_req_i | input | 1 | One-cycle interrupt request strobe |
| has_payload_i | input | 1 | Send a payload byte after the acknowledge |
| payload_i | input | 8 | Mandatory data byte |
| sda_od_oe | output | 1 | Open-drain pull-low enable |
| sda_pp_oe | output | 1 | Push-pull drive enable |
| sda_pp_val | output | 1 | Push-pull drive value |
| done_o | output | 1 | Pulse: interrupt delivered |
| abort_o | output | 1 | Pulse: ended by not-acknowledge or STOP |
| lost_o | output | 1 | Pulse: arbitration lost |

## Verification
Each SCL edge is detected in the clock cycle that first samples it. The outputs it causes change one clock later, and a status pulse lasts one clock. The start request follows the AVAIL_CYC-th idle sample by one to two clocks, depending on the internal reset synchroniser. The bench holds every SCL half period for eight clocks and reads SDA in the middle of each high half, well after any output update. Status pulses are counted on every clock and compared only after a transaction has fully finished.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_TAIL
  } ibi_state_e;
endpackage

// File: rtl/ibi_line_mon.sv
module ibi_line_mon #(
  parameter int AVAIL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic stop_seen,
  output logic bus_avail
);
  localparam int CW = $clog2(AVAIL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(AVAIL_CYC);

  logic scl_q, sda_q;
  logic [CW-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    if (!(scl_i && sda_i))   idle_d = '0;
    else if (idle_q != CNT_MAX) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      idle_q <= '0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      idle_q <= idle_d;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign stop_seen = scl_i & scl_q & sda_i & ~sda_q;
  assign bus_avail = (idle_q == CNT_MAX);

  AST_AVAIL_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avail |-> $past(scl_i) && $past(sda_i)); // R1
endmodule

// File: rtl/ibi_shreg.sv
module ibi_shreg #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          shift,
  output logic          msb,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = load_val;
      cnt_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb = sh_q[W-1];
  assign cnt = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> cnt_q <= CW'(W)); // R3
endmodule

// File: rtl/ibi_requester.sv
module ibi_requester
  import ibi_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int AVAIL_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dyn_addr_i,
  input  logic              irq_req_i,
  input  logic              has_payload_i,
  input  logic [DATA_W-1:0] payload_i,
  output logic              sda_od_oe,
  output logic              sda_pp_oe,
  output logic              sda_pp_val,
  output logic              done_o,
  output logic              abort_o,
  output logic              lost_o
);
  localparam int SH_W = (ADDR_W + 1 > DATA_W) ? ADDR_W + 1 : DATA_W;
  localparam int CW   = $clog2(SH_W + 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic scl_rise, scl_fall, stop_seen, bus_avail;

  ibi_line_mon #(.AVAIL_CYC(AVAIL_CYC)) u_mon (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .stop_seen (stop_seen),
    .bus_avail (bus_avail)
  );

  logic            sh_load, sh_shift, sh_msb;
  logic [SH_W-1:0] sh_val;
  logic [CW-1:0]   sh_cnt;

  ibi_shreg #(.W(SH_W), .CW(CW)) u_sh (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .msb      (sh_msb),
    .cnt      (sh_cnt)
  );

  ibi_state_e state_q, state_d;
  logic pend_q, pend_d;
  logic od_q, od_d, ppoe_q, ppoe_d, ppval_q, ppval_d;
  logic done_q, done_d, abort_q, abort_d, lost_q, lost_d;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q | irq_req_i;
    od_d     = od_q;
    ppoe_d   = ppoe_q;
    ppval_d  = ppval_q;
    done_d   = 1'b0;
    abort_d  = 1'b0;
    lost_d   = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_q && bus_avail) begin
          state_d = ST_REQ;
          od_d    = 1'b1;
          sh_load = 1'b1;
          sh_val[SH_W-1 -: ADDR_W+1] = {dyn_addr_i, 1'b1};
        end
      end
      ST_REQ: begin
        if (scl_fall) begin
          state_d = ST_ADDR;
          od_d    = ~sh_msb;
        end
      end
      ST_ADDR: begin
        if (stop_seen) begin
          state_d = ST_IDLE; od_d = 1'b0; abort_d = 1'b1; pend_d = 1'b0;
        end else if (scl_rise) begin
          if (sh_msb && !sda_i) begin
            state_d = ST_IDLE; od_d = 1'b0; lost_d = 1'b1; pend_d = 1'b0;
          end else begin
            sh_shift = 1'b1;
            if (sh_cnt == ADDR_LAST) state_d = ST_ACK;
          end
        end else if (scl_fall) begin
          od_d = ~sh_msb;
        end
      end
      ST_ACK: begin
        if (stop_seen) begin
          state_d = ST_IDLE; od_d = 1'b0; abort_d = 1'b1; pend_d = 1'b0;
        end else if (scl_fall) begin
          od_d = 1'b0;
        end else if (scl_rise) begin
          if (sda_i) begin
            state_d = ST_IDLE; abort_d = 1'b1; pend_d = 1'b0;
          end else if (has_payload_i) begin
            state_d = ST_DATA;
            sh_load = 1'b1;
            sh_val[SH_W-1 -: DATA_W] = payload_i;
          end else begin
            state_d = ST_IDLE; done_d = 1'b1; pend_d = 1'b0;
          end
        end
      end
      ST_DATA: begin
        if (stop_seen) begin
          state_d = ST_IDLE; ppoe_d = 1'b0; abort_d = 1'b1; pend_d = 1'b0;
        end else if (scl_fall) begin
          ppoe_d  = 1'b1;
          ppval_d = sh_msb;
        end else if (scl_rise) begin
          sh_shift = 1'b1;
          if (sh_cnt == DATA_LAST) state_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (stop_seen) begin
          state_d = ST_IDLE; ppoe_d = 1'b0; abort_d = 1'b1; pend_d = 1'b0;
        end else if (scl_fall) begin
          state_d = ST_IDLE; ppoe_d = 1'b0; done_d = 1'b1; pend_d = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE; od_d = 1'b0; ppoe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      od_q    <= 1'b0;
      ppoe_q  <= 1'b0;
      ppval_q <= 1'b1;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      od_q    <= od_d;
      ppoe_q  <= ppoe_d;
      ppval_q <= ppval_d;
      done_q  <= done_d;
      abort_q <= abort_d;
      lost_q  <= lost_d;
    end
  end

  assign sda_od_oe  = od_q;
  assign sda_pp_oe  = ppoe_q;
  assign sda_pp_val = ppval_q;
  assign done_o     = done_q;
  assign abort_o    = abort_q;
  assign lost_o     = lost_q;

  AST_REQ_ON_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_REQ && $past(state_q) == ST_IDLE) |-> $past(bus_avail)); // R1
  AST_REQ_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_REQ) |-> sda_od_oe); // R2
  AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rst_int_n)
    lost_o |-> !sda_od_oe && !sda_pp_oe); // R4
  AST_PP_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sda_pp_oe && !$stable(sda_pp_val)) |-> !scl_i); // R7
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(sda_od_oe && sda_pp_oe)); // R7
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_seen && state_q != ST_IDLE && state_q != ST_REQ) |=> abort_o); // R9
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({done_o, abort_o, lost_o})); // R10
endmodule

// File: tb/tb_ibi_requester.sv
module tb_ibi_requester;
  localparam int AVAIL = 16;
  localparam int H     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       scl = 1'b1;
  logic       m_low = 1'b0, c_low = 1'b0;
  logic [6:0] dyn = '0;
  logic       irq = 1'b0, has_pl = 1'b0;
  logic [7:0] pl = '0;
  logic       od_oe, pp_oe, pp_val, done_p, abort_p, lost_p;
  logic       sda_line;

  assign sda_line = ~od_oe & ~m_low & ~c_low & (pp_oe ? pp_val : 1'b1);

  ibi_requester #(.ADDR_W(7), .DATA_W(8), .AVAIL_CYC(AVAIL)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dyn_addr_i(dyn), .irq_req_i(irq), .has_payload_i(has_pl), .payload_i(pl),
    .sda_od_oe(od_oe), .sda_pp_oe(pp_oe), .sda_pp_val(pp_val),
    .done_o(done_p), .abort_o(abort_p), .lost_o(lost_p)
  );

  int n_done = 0, n_abort = 0, n_lost = 0;
  always @(posedge clk) begin
    if (done_p)  n_done  <= n_done + 1;
    if (abort_p) n_abort <= n_abort + 1;
    if (lost_p)  n_lost  <= n_lost + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int wait_cnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [6:0] a, input logic hp, input logic [7:0] d);
    dyn = a; has_pl = hp; pl = d;
    @(negedge clk) irq = 1'b1;
    @(negedge clk) irq = 1'b0;
  endtask

  // Controller model plus an optional competing requester.
  task automatic transact(input logic [6:0] a, input logic hp, input logic [7:0] d,
                          input bit comp_en, input logic [6:0] comp,
                          input bit ack, input int stop_bit, input bit do_strobe);
    int d0, a0, l0;
    logic [7:0] cap_a, cap_d;
    logic [6:0] exp_a;
    bit cstill, cbit, exp_lost;
    d0 = n_done; a0 = n_abort; l0 = n_lost;
    if (do_strobe) strobe(a, hp, d);
    wait_cnt = 0;
    while (sda_line && wait_cnt < 400) begin
      nclk(1);
      wait_cnt++;
    end
    cstill = comp_en;
    cap_a = '0; cap_d = '0;
    nclk(H); scl = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cbit = (i < 7) ? comp[6-i] : 1'b1;
      c_low = cstill & ~cbit;
      nclk(H); scl = 1'b1;
      nclk(H/2);
      cap_a = {cap_a[6:0], sda_line};
      if (cstill && cbit && !sda_line) cstill = 1'b0;
      if (i == stop_bit) begin
        m_low = 1'b1; nclk(2); m_low = 1'b0; nclk(4);
        chk(n_abort == a0 + 1, "R9 stop abort count", n_abort - a0, 1);
        chk(!od_oe && !pp_oe, "R9 stop release", {od_oe, pp_oe}, 0);
        c_low = 1'b0;
        nclk(AVAIL);
        return;
      end
      nclk(H/2); scl = 1'b0;
    end
    c_low = 1'b0;
    exp_lost = comp_en && (comp < a);
    exp_a = (comp_en && comp < a) ? comp : a;
    chk(cap_a == {exp_a, 1'b1}, "R3/R4 address on line", cap_a, {exp_a, 1'b1});
    m_low = ack;
    nclk(H); scl = 1'b1; nclk(H); scl = 1'b0; m_low = 1'b0;
    if (ack && hp && !exp_lost) begin
      for (int i = 0; i < 8; i++) begin
        nclk(H); scl = 1'b1;
        nclk(H/2); cap_d = {cap_d[6:0], sda_line};
        nclk(H/2); scl = 1'b0;
      end
      chk(cap_d == d, "R7 payload on line", cap_d, d);
    end
    nclk(H);
    chk(!pp_oe && !od_oe, "R8 lines released at end", {od_oe, pp_oe}, 0);
    m_low = 1'b1; nclk(H); scl = 1'b1; nclk(H); m_low = 1'b0; nclk(H);
    if (exp_lost) begin
      chk(n_lost == l0 + 1 && n_done == d0 && n_abort == a0, "R4 lost status",
          n_lost - l0, 1);
    end else if (!ack) begin
      chk(n_abort == a0 + 1 && n_done == d0, "R6 nack abort", n_abort - a0, 1);
    end else begin
      chk(n_done == d0 + 1 && n_abort == a0 && n_lost == l0, "R8/R10 done status",
          n_done - d0, 1);
    end
    nclk(AVAIL + 4);
  endtask

  initial begin
    nclk(5);
    rst_n = 1'b1;
    nclk(4);
    chk({od_oe, pp_oe, done_p, abort_p, lost_p} == 5'b0, "R2 reset outputs",
        {od_oe, pp_oe, done_p, abort_p, lost_p}, 0);
    nclk(AVAIL + 4);

    // R1: request while the bus is busy stays pending
    scl = 1'b0;
    strobe(7'h2C, 1'b1, 8'hC3);
    nclk(40);
    chk(!od_oe, "R1 no drive while busy", od_oe, 0);
    scl = 1'b1;
    transact(7'h2C, 1'b1, 8'hC3, 1'b0, 7'h00, 1'b1, -1, 1'b0);
    chk(wait_cnt >= AVAIL && wait_cnt <= AVAIL + 3, "R1 free-bus delay", wait_cnt, AVAIL);

    // R3/R5/R7/R8: every address, payload or not
    for (int a = 0; a < 128; a++) begin
      transact(7'(a), (a % 4) != 3, 8'(a * 37) ^ 8'h5A, 1'b0, 7'h00, 1'b1, -1, 1'b1);
    end

    // R4: arbitration against a competing requester
    transact(7'h40, 1'b1, 8'h11, 1'b1, 7'h3F, 1'b1, -1, 1'b1);
    transact(7'h12, 1'b1, 8'hE7, 1'b1, 7'h13, 1'b1, -1, 1'b1);
    transact(7'h7F, 1'b0, 8'h00, 1'b1, 7'h00, 1'b1, -1, 1'b1);
    transact(7'h00, 1'b1, 8'h81, 1'b1, 7'h7F, 1'b1, -1, 1'b1);
    transact(7'h55, 1'b1, 8'h3C, 1'b1, 7'h54, 1'b1, -1, 1'b1);

    // R6: not-acknowledge
    transact(7'h33, 1'b1, 8'hAA, 1'b0, 7'h00, 1'b0, -1, 1'b1);
    // R9: STOP during the address phase
    transact(7'h55, 1'b1, 8'hAA, 1'b0, 7'h00, 1'b1, 0, 1'b1);
    transact(7'h55, 1'b0, 8'h00, 1'b0, 7'h00, 1'b1, 2, 1'b1);
    // After an abort the block serves a fresh request normally
    transact(7'h01, 1'b1, 8'hFE, 1'b0, 7'h00, 1'b1, -1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=0x%0h expected=0x%0h", n_chk, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule